// File: doc/BRIEF.md
# Coulomb and Activity Time Counters

This block counts battery charge activity for a fuel-gauge subsystem. An external voltage-to-frequency converter produces single-cycle pulses. Each pulse carries a polarity that says whether current flows into the pack or out of it. Each pulse adds one to either a charge tally or a discharge tally. A low-rate timebase strobe drives two activity timers. One timer runs while the pack is discharging and the other while it is charging. The direction is taken from the most recent converter pulse.

The activity timers count at their normal rate until they wrap. After a wrap they drop to a slow rate: one count for every 2^PRE_W timebase strobes. A status flag reports each timer that is in slow mode. A second wrap cancels slow mode. A host clear also cancels slow mode.

The host reaches the block through a small register port with byte-wide data. Writes go to a self-clearing clear register. Reads return the counters, the clear register and the slow-mode status, one cycle after the address is presented.

Top module: `coulomb_activity_counters`

## Requirements
- R1: A pulse on `vfc_pulse` with `vfc_dir`=0 (discharge) adds one to the discharge tally, and one with `vfc_dir`=1 (charge) adds one to the charge tally. The other tally is left unchanged.
- R2: Each tally wraps from all ones to zero. The wrap sets no flag, and the status register is unaffected.
- R3: The activity direction is the polarity of the latest converter pulse. Before the first pulse, no timer advances. After it, each `tick` adds one to the timer of the active direction only.
- R4: When a timer wraps from all ones to zero at the normal rate, its slow flag is set. Status bit 0 is the discharge timer's flag and bit 1 is the charge timer's. From then on the timer advances once per 2^PRE_W ticks of its direction.
- R5: A timer that wraps while in slow mode clears its slow flag and returns to one count per tick.
- R6: The clear register is at address 8. Bit 0 clears the discharge tally, bit 1 the charge tally, bit 3 the discharge timer and bit 4 the charge timer. A 1 written to a bit zeroes its counter on the next cycle, and the bit then reads back as 0. Bit 2 and bits 7..5 have no effect.
- R7: Clearing a timer also clears its slow flag and restores the one-count-per-tick rate.
- R8: When a clear and an increment reach the same counter in the same cycle, the counter ends at zero.
- R9: After reset, every counter, both slow flags and the clear register read as zero.
- R10: The register map is as follows. Each pair lists the low byte first, then the high byte, and each value is zero-extended to 16 bits:
  - the discharge tally is at addresses 0 and 1;
  - the charge tally is at 2 and 3;
  - the discharge timer is at 4 and 5;
  - the charge timer is at 6 and 7;
  - the status register is at address 9.
  Read data appears one cycle after the address. Unmapped addresses read 0. Writes to any address other than 8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vfc_pulse | input | 1 | Single-cycle converter pulse |
| vfc_dir | input | 1 | Pulse polarity: 1 charge, 0 discharge |
| tick | input | 1 | Single-cycle timebase strobe |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | ADDR_W | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Registered read data |

## Verification
The bench uses an 8-bit counter and a 3-bit prescaler. This keeps every wrap short enough to run in full, with expected values worked out arithmetically.

It checks the following corners, each with a specific failure it would expose:
- Ticks that arrive before any pulse. A design that assumes a default direction would count them.
- The exact tick on which a timer wraps into slow mode. An off-by-one in the wrap logic would show here.
- The 2^PRE_W spacing of slow counts. A prescaler that is not reset on entry would give an early first count.
- The second wrap back to normal rate. A one-way mode flag would stay stuck in slow mode.
- A clear that lands in the same cycle as a pulse. A design that lets the increment win would leave a count of 1.
- Writes to reserved clear bits and to counter addresses. A design that decodes these would alter counts.

// File: rtl/cac_pkg.sv
package cac_pkg;
  localparam int REG_ADDR_W = 4;
  localparam logic [REG_ADDR_W-1:0] A_DIS_LO = 4'd0;
  localparam logic [REG_ADDR_W-1:0] A_DIS_HI = 4'd1;
  localparam logic [REG_ADDR_W-1:0] A_CHG_LO = 4'd2;
  localparam logic [REG_ADDR_W-1:0] A_CHG_HI = 4'd3;
  localparam logic [REG_ADDR_W-1:0] A_DTM_LO = 4'd4;
  localparam logic [REG_ADDR_W-1:0] A_DTM_HI = 4'd5;
  localparam logic [REG_ADDR_W-1:0] A_CTM_LO = 4'd6;
  localparam logic [REG_ADDR_W-1:0] A_CTM_HI = 4'd7;
  localparam logic [REG_ADDR_W-1:0] A_CLEAR  = 4'd8;
  localparam logic [REG_ADDR_W-1:0] A_STATUS = 4'd9;

  // clear register bit positions
  localparam int CB_DIS = 0;
  localparam int CB_CHG = 1;
  localparam int CB_DTM = 3;
  localparam int CB_CTM = 4;
  localparam logic [7:0] CLR_MASK = 8'b0001_1011;

  typedef struct packed {
    logic dis_cnt;
    logic chg_cnt;
    logic dis_tm;
    logic chg_tm;
  } clr_req_t;
endpackage

// File: rtl/cac_event_ctr.sv
module cac_event_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/cac_time_ctr.sv
module cac_time_ctr #(
  parameter int W     = 16,
  parameter int PRE_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         active,
  input  logic         clr,
  output logic [W-1:0] count,
  output logic         slow
);
  localparam logic [PRE_W-1:0] PRE_LAST = '1;
  localparam logic [W-1:0]     CNT_LAST = '1;

  logic [PRE_W-1:0] pre;
  logic             step;
  logic             adv;

  assign step = tick && active;
  assign adv  = step && (!slow || pre == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      slow  <= 1'b0;
      pre   <= '0;
    end else begin
      if (step && slow) pre <= pre + 1'b1;
      if (adv) begin
        if (count == CNT_LAST) begin
          count <= '0;
          slow  <= !slow;
          pre   <= '0;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cac_host_regs.sv
module cac_host_regs
  import cac_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [CNT_W-1:0]  dis_cnt,
  input  logic [CNT_W-1:0]  chg_cnt,
  input  logic [CNT_W-1:0]  dis_tm,
  input  logic [CNT_W-1:0]  chg_tm,
  input  logic              dis_slow,
  input  logic              chg_slow,
  output logic [7:0]        clr_pend,
  output clr_req_t          clr_req,
  output logic [7:0]        rdata
);
  logic [15:0] x_dis, x_chg, x_dtm, x_ctm;
  logic [7:0]  rd_next;

  always_comb begin
    x_dis = '0; x_dis[CNT_W-1:0] = dis_cnt;
    x_chg = '0; x_chg[CNT_W-1:0] = chg_cnt;
    x_dtm = '0; x_dtm[CNT_W-1:0] = dis_tm;
    x_ctm = '0; x_ctm[CNT_W-1:0] = chg_tm;
  end

  assign clr_req.dis_cnt = clr_pend[CB_DIS];
  assign clr_req.chg_cnt = clr_pend[CB_CHG];
  assign clr_req.dis_tm  = clr_pend[CB_DTM];
  assign clr_req.chg_tm  = clr_pend[CB_CTM];

  // pending bits live one cycle, then self-clear
  always_ff @(posedge clk) begin
    if (rst)                       clr_pend <= '0;
    else if (wr && addr == ADDR_W'(A_CLEAR)) clr_pend <= wdata & CLR_MASK;
    else                           clr_pend <= '0;
  end

  always_comb begin
    case (addr)
      ADDR_W'(A_DIS_LO): rd_next = x_dis[7:0];
      ADDR_W'(A_DIS_HI): rd_next = x_dis[15:8];
      ADDR_W'(A_CHG_LO): rd_next = x_chg[7:0];
      ADDR_W'(A_CHG_HI): rd_next = x_chg[15:8];
      ADDR_W'(A_DTM_LO): rd_next = x_dtm[7:0];
      ADDR_W'(A_DTM_HI): rd_next = x_dtm[15:8];
      ADDR_W'(A_CTM_LO): rd_next = x_ctm[7:0];
      ADDR_W'(A_CTM_HI): rd_next = x_ctm[15:8];
      ADDR_W'(A_CLEAR):  rd_next = clr_pend;
      ADDR_W'(A_STATUS): rd_next = {6'b0, chg_slow, dis_slow};
      default:           rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/coulomb_activity_counters.sv
module coulomb_activity_counters
  import cac_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = REG_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vfc_pulse,
  input  logic              vfc_dir,
  input  logic              tick,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic [CNT_W-1:0] dis_cnt, chg_cnt, dis_tm, chg_tm;
  logic             dis_slow, chg_slow;
  logic [7:0]       clr_pend;
  clr_req_t         clr_req;
  logic             dir_valid, dir_chg;

  // activity direction held from the latest converter pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_valid <= 1'b0;
      dir_chg   <= 1'b0;
    end else if (vfc_pulse) begin
      dir_valid <= 1'b1;
      dir_chg   <= vfc_dir;
    end
  end

  cac_event_ctr #(.W(CNT_W)) u_dis_cnt (
    .clk(clk), .rst(rst), .inc(vfc_pulse && !vfc_dir),
    .clr(clr_req.dis_cnt), .count(dis_cnt));

  cac_event_ctr #(.W(CNT_W)) u_chg_cnt (
    .clk(clk), .rst(rst), .inc(vfc_pulse && vfc_dir),
    .clr(clr_req.chg_cnt), .count(chg_cnt));

  cac_time_ctr #(.W(CNT_W), .PRE_W(PRE_W)) u_dis_tm (
    .clk(clk), .rst(rst), .tick(tick), .active(dir_valid && !dir_chg),
    .clr(clr_req.dis_tm), .count(dis_tm), .slow(dis_slow));

  cac_time_ctr #(.W(CNT_W), .PRE_W(PRE_W)) u_chg_tm (
    .clk(clk), .rst(rst), .tick(tick), .active(dir_valid && dir_chg),
    .clr(clr_req.chg_tm), .count(chg_tm), .slow(chg_slow));

  cac_host_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dis_cnt(dis_cnt), .chg_cnt(chg_cnt), .dis_tm(dis_tm), .chg_tm(chg_tm),
    .dis_slow(dis_slow), .chg_slow(chg_slow),
    .clr_pend(clr_pend), .clr_req(clr_req), .rdata(reg_rdata));
endmodule

// File: rtl/cac_checker.sv
module cac_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             vfc_pulse,
  input logic             vfc_dir,
  input logic             dir_valid,
  input logic [7:0]       clr_pend,
  input logic [CNT_W-1:0] dis_cnt,
  input logic [CNT_W-1:0] dis_tm,
  input logic [CNT_W-1:0] chg_tm,
  input logic             chg_slow
);
  localparam logic [CNT_W-1:0] LAST = '1;

  assert_pulse_inc_R1: assert property (@(posedge clk) disable iff (rst)
    (vfc_pulse && !vfc_dir && !clr_pend[0]) |=> dis_cnt == $past(dis_cnt) + 1'b1);

  assert_no_stray_inc_R1: assert property (@(posedge clk) disable iff (rst)
    (!(vfc_pulse && !vfc_dir) && !clr_pend[0]) |=> $stable(dis_cnt));

  assert_idle_before_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    !dir_valid |=> (dis_tm == '0 && chg_tm == '0));

  assert_wrap_sets_slow_R4: assert property (@(posedge clk) disable iff (rst)
    (chg_tm == LAST && !chg_slow && !clr_pend[4]) |=> (chg_slow == (chg_tm == '0)));

  assert_clear_self_resets_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_pend != 8'h00) |=> (clr_pend == 8'h00 || $past(clr_pend) == 8'h00));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr_pend[0] |=> dis_cnt == '0);

  assert_clear_slow_R7: assert property (@(posedge clk) disable iff (rst)
    clr_pend[4] |=> (!chg_slow && chg_tm == '0));
endmodule

bind coulomb_activity_counters cac_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .vfc_pulse(vfc_pulse), .vfc_dir(vfc_dir),
  .dir_valid(dir_valid), .clr_pend(clr_pend), .dis_cnt(dis_cnt),
  .dis_tm(dis_tm), .chg_tm(chg_tm), .chg_slow(chg_slow));

// File: tb/sim_coulomb_activity_counters.sv
`timescale 1ns/1ps
module sim_coulomb_activity_counters;
  localparam int CW = 8;
  localparam int PW = 3;
  localparam int SLOW = 1 << PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vfc_pulse = 1'b0, vfc_dir = 1'b0, tick = 1'b0, reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  int checks = 0, fails = 0;
  logic [15:0] v;

  always #10 clk = ~clk;

  coulomb_activity_counters #(.CNT_W(CW), .PRE_W(PW), .ADDR_W(4)) u0 (
    .clk(clk), .rst(rst), .vfc_pulse(vfc_pulse), .vfc_dir(vfc_dir), .tick(tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic rd16(input logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd8(a, lo); rd8(a + 4'd1, hi);
    d = {hi, lo};
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic pulses(input logic dir, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); vfc_pulse = 1'b1; vfc_dir = dir;
    end
    @(negedge clk); vfc_pulse = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: all registers zero after reset
    for (int a = 0; a < 10; a++) begin
      rd8(4'(a), b); check("R9 reset value", b, 0);
    end
    // R3: no advance before any pulse
    ticks(10);
    rd16(4'd4, v); check("R3 dis timer idle", v, 0);
    rd16(4'd6, v); check("R3 chg timer idle", v, 0);
    // R1: discharge pulses
    pulses(1'b0, 5);
    rd16(4'd0, v); check("R1 dis tally", v, 5);
    rd16(4'd2, v); check("R1 chg tally untouched", v, 0);
    // R3: discharge timer only
    ticks(12);
    rd16(4'd4, v); check("R3 dis timer", v, 12);
    rd16(4'd6, v); check("R3 chg timer held", v, 0);
    pulses(1'b1, 7);
    rd16(4'd2, v); check("R1 chg tally", v, 7);
    ticks(9);
    rd16(4'd6, v); check("R3 chg timer", v, 9);
    rd16(4'd4, v); check("R3 dis timer held", v, 12);
    // R2: tally wrap, no flag
    pulses(1'b1, 1 << CW);
    rd16(4'd2, v); check("R2 chg tally wrap", v, 7);
    rd8(4'd9, b);  check("R2 status after wrap", b, 0);
    // R10: writes elsewhere ignored, unmapped reads zero
    wr8(4'd0, 8'hAA);
    rd16(4'd0, v); check("R10 write to tally ignored", v, 5);
    rd8(4'd12, b); check("R10 unmapped read", b, 0);
    // R6: clear charge timer only
    wr8(4'd8, 8'h10);
    rd8(4'd8, b);  check("R6 clear bit self-resets", b, 0);
    rd16(4'd6, v); check("R6 chg timer cleared", v, 0);
    rd16(4'd2, v); check("R6 chg tally kept", v, 7);
    wr8(4'd8, 8'hE4);
    rd16(4'd0, v); check("R6 reserved bits dis tally", v, 5);
    rd16(4'd2, v); check("R6 reserved bits chg tally", v, 7);
    rd16(4'd4, v); check("R6 reserved bits dis timer", v, 12);
    // R4: wrap into slow mode
    ticks((1 << CW) - 1);
    rd16(4'd6, v); check("R4 before wrap", v, (1 << CW) - 1);
    rd8(4'd9, b);  check("R4 no flag before wrap", b, 0);
    ticks(1);
    rd16(4'd6, v); check("R4 wrapped", v, 0);
    rd8(4'd9, b);  check("R4 chg slow flag", b, 2);
    ticks(SLOW - 1);
    rd16(4'd6, v); check("R4 slow hold", v, 0);
    ticks(1);
    rd16(4'd6, v); check("R4 slow first count", v, 1);
    ticks(2 * SLOW);
    rd16(4'd6, v); check("R4 slow rate", v, 3);
    // R5: second wrap returns to normal
    ticks(((1 << CW) - 3) * SLOW);
    rd16(4'd6, v); check("R5 second wrap", v, 0);
    rd8(4'd9, b);  check("R5 flag cleared", b, 0);
    ticks(4);
    rd16(4'd6, v); check("R5 normal rate", v, 4);
    // R7: discharge timer slow then cleared
    pulses(1'b0, 1);
    ticks((1 << CW) - 12);
    rd8(4'd9, b);  check("R4 dis slow flag", b, 1);
    ticks(SLOW);
    rd16(4'd4, v); check("R4 dis slow count", v, 1);
    wr8(4'd8, 8'h08);
    rd16(4'd4, v); check("R7 dis timer cleared", v, 0);
    rd8(4'd9, b);  check("R7 dis flag cleared", b, 0);
    ticks(3);
    rd16(4'd4, v); check("R7 normal rate restored", v, 3);
    // R8: clear coincides with pulse
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h01;
    @(negedge clk); reg_wr = 1'b0; vfc_pulse = 1'b1; vfc_dir = 1'b0;
    @(negedge clk); vfc_pulse = 1'b0;
    rd16(4'd0, v); check("R8 dis clear wins", v, 0);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h02;
    @(negedge clk); reg_wr = 1'b0; vfc_pulse = 1'b1; vfc_dir = 1'b1;
    @(negedge clk); vfc_pulse = 1'b0;
    rd16(4'd2, v); check("R8 chg clear wins", v, 0);
    finish_run();
  end
endmodule